// File: doc/BRIEF.md
# Command Stream Word Parser

This block sits at the front of a command processor. It takes a stream of 32-bit command words and decides, word by word, whether each one is a header or a payload word. A header is classified by its four-bit opcode and its fields are unpacked into a decoded record. The parser then works out how many payload words follow that header and counts them off, so that the next header is found at the right place in the stream. Each payload word goes out tagged with the register offset it targets. Executing the writes, fetching gathered memory and timeouts are left to later stages.

Both edges are valid/ready streams. An input word is accepted on a clock edge where `in_valid` and `in_ready` are both high. Exactly one output beat is produced for each accepted word, and it appears on the outputs in the next cycle. The output is held by a single-entry register. `in_ready` is high when that register is empty or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every output stays frozen and no new input is taken. Back-pressure therefore passes straight through to the source with no extra buffering.

Top module: `cmd_word_parser`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted word's beat is presented with `out_valid` high in the next cycle. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R2: A word accepted with no payload outstanding is a header: `out_payload`=0, `out_opcode`=word[31:28], `out_data`=word. Opcodes 7 to 13 and 15 give `out_count`=0, and every decoded field is zero.
- R3: Opcode 0 (set class): `out_class`=word[15:6], `out_offset`=word[27:16], `out_mask`=word[5:0] zero-extended, and `out_count`=popcount of word[5:0]. A zero mask therefore gives no payload.
- R4: Opcodes 1 (stepping write) and 2 (fixed write): `out_offset`=word[27:16] and `out_count`=word[15:0]. Payload word i of opcode 1 is tagged offset+i, wrapping modulo 4096. Every payload word of opcode 2 is tagged with the offset itself.
- R5: Opcode 3 (masked write): `out_mask`=word[15:0] and `out_count`=its popcount. The payload words of opcodes 0 and 3 are tagged offset+p, where p is the position of each set mask bit, taken from bit 0 upward.
- R6: Opcode 4 (immediate): `out_imm`=word[15:0], `out_offset`=word[27:16], `out_count`=0.
- R7: Opcode 5 (restart): `out_restart_addr`={word[27:0],4'b0}, `out_count`=0.
- R8: Opcode 6 (gather): `out_insert`=word[15], `out_gtype`=word[14], `out_gcount`=word[13:0], `out_offset`=word[27:16], `out_count`=1. The one payload word is tagged with that offset.
- R9: Opcode 14 (extend): `out_index`=word[7:0]. Sub-opcode word[27:24]=0 sets `out_lock_acq` and 1 sets `out_lock_rel`; any other value sets `out_unknown`. `out_count`=0.
- R10: While payload words remain, every accepted word is output as payload (`out_payload`=1, `out_data`=word), whatever its bits 31:28 hold.
- R11: `out_last` is 1 only on the final payload word of a header. A header with `out_count`=0 is followed directly by another header.
- R12: After reset `out_valid`=0, `in_ready`=1, and the first accepted word is a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be taken |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_payload | output | 1 | 1 = payload word, 0 = header |
| out_last | output | 1 | Final payload word of its header |
| out_data | output | 32 | Raw accepted word |
| out_opcode | output | 4 | Header opcode |
| out_class | output | 10 | Set-class class field |
| out_offset | output | 12 | Header offset, or the target offset of a payload word |
| out_mask | output | 16 | Write mask (set class or masked write) |
| out_count | output | 16 | Number of payload words that follow |
| out_imm | output | 16 | Immediate data |
| out_gcount | output | 14 | Gather word count field |
| out_insert | output | 1 | Gather insert flag |
| out_gtype | output | 1 | Gather type flag |
| out_lock_acq | output | 1 | Extend: acquire lock |
| out_lock_rel | output | 1 | Extend: release lock |
| out_unknown | output | 1 | Extend: unknown sub-opcode |
| out_index | output | 8 | Extend index |
| out_restart_addr | output | 32 | Restart byte address |

## Verification
Every result is due exactly one cycle after the edge at which its word is accepted: header fields, payload tags and the last flag are all registered together in the output slice. The bench sets its inputs at the falling edge and evaluates both handshakes there, after a short settle delay. It queues the expected beat when an input transfer is committed and compares the queue head only on a falling edge where `out_valid` and `out_ready` are both high. Each beat is therefore checked in the cycle it is actually consumed, however long the random back-pressure held it. On stalled cycles the bench also checks, at the next falling edge, that the held beat did not change.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  parameter int WORD_W = 32;
  parameter int OP_W   = 4;
  parameter int OFF_W  = 12;
  parameter int CLS_W  = 10;
  parameter int MASK_W = 16;
  parameter int SCM_W  = 6;
  parameter int CNT_W  = 16;
  parameter int GCNT_W = 14;
  parameter int IDX_W  = 8;
  parameter int SUB_W  = 4;
  parameter int POS_W  = $clog2(MASK_W);

  localparam logic [OP_W-1:0] OP_SETCL   = 4'h0;
  localparam logic [OP_W-1:0] OP_STEP    = 4'h1;
  localparam logic [OP_W-1:0] OP_FIXED   = 4'h2;
  localparam logic [OP_W-1:0] OP_MASKED  = 4'h3;
  localparam logic [OP_W-1:0] OP_IMM     = 4'h4;
  localparam logic [OP_W-1:0] OP_RESTART = 4'h5;
  localparam logic [OP_W-1:0] OP_GATHER  = 4'h6;
  localparam logic [OP_W-1:0] OP_EXTEND  = 4'hE;

  typedef enum logic [1:0] {TAG_STEP, TAG_FIXED, TAG_MASK} tag_mode_e;

  typedef struct packed {
    logic              is_payload;
    logic              last;
    logic [WORD_W-1:0] data;
    logic [OP_W-1:0]   opcode;
    logic [CLS_W-1:0]  cls;
    logic [OFF_W-1:0]  offset;
    logic [MASK_W-1:0] mask;
    logic [CNT_W-1:0]  count;
    logic [15:0]       imm;
    logic [GCNT_W-1:0] gcount;
    logic              insert;
    logic              gtype;
    logic              acq;
    logic              rel;
    logic              unknown;
    logic [IDX_W-1:0]  index;
    logic [WORD_W-1:0] raddr;
  } beat_t;

  function automatic logic [CNT_W-1:0] popcount(input logic [MASK_W-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < MASK_W; i++) n = n + CNT_W'(m[i]);
    return n;
  endfunction

  function automatic logic [POS_W-1:0] lowest_set(input logic [MASK_W-1:0] m);
    logic [POS_W-1:0] p;
    p = '0;
    for (int i = MASK_W - 1; i >= 0; i--) if (m[i]) p = POS_W'(i);
    return p;
  endfunction
endpackage

// File: rtl/cwp_hdr_decode.sv
module cwp_hdr_decode
  import cwp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output beat_t             hdr,
  output tag_mode_e         mode,
  output logic [MASK_W-1:0] walk_mask
);
  logic [OP_W-1:0]  op;
  logic [SUB_W-1:0] sub;
  logic [OFF_W-1:0] off_f;

  assign op    = word[31:28];
  assign sub   = word[27:24];
  assign off_f = word[27:16];

  always_comb begin
    hdr        = '0;
    hdr.data   = word;
    hdr.opcode = op;
    mode       = TAG_FIXED;
    walk_mask  = '0;
    case (op)
      OP_SETCL: begin
        hdr.cls    = word[15:6];
        hdr.offset = off_f;
        hdr.mask   = MASK_W'(word[SCM_W-1:0]);
        hdr.count  = popcount(MASK_W'(word[SCM_W-1:0]));
        mode       = TAG_MASK;
        walk_mask  = MASK_W'(word[SCM_W-1:0]);
      end
      OP_STEP, OP_FIXED: begin
        hdr.offset = off_f;
        hdr.count  = word[CNT_W-1:0];
        mode       = (op == OP_STEP) ? TAG_STEP : TAG_FIXED;
      end
      OP_MASKED: begin
        hdr.offset = off_f;
        hdr.mask   = word[MASK_W-1:0];
        hdr.count  = popcount(word[MASK_W-1:0]);
        mode       = TAG_MASK;
        walk_mask  = word[MASK_W-1:0];
      end
      OP_IMM: begin
        hdr.offset = off_f;
        hdr.imm    = word[15:0];
      end
      OP_RESTART: hdr.raddr = {word[WORD_W-5:0], 4'b0000};
      OP_GATHER: begin
        hdr.offset = off_f;
        hdr.insert = word[15];
        hdr.gtype  = word[14];
        hdr.gcount = word[GCNT_W-1:0];
        hdr.count  = CNT_W'(1);
      end
      OP_EXTEND: begin
        hdr.index   = word[IDX_W-1:0];
        hdr.acq     = (sub == 4'h0);
        hdr.rel     = (sub == 4'h1);
        hdr.unknown = (sub != 4'h0) && (sub != 4'h1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cwp_payload_seq.sv
module cwp_payload_seq
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CNT_W-1:0]  hdr_count,
  input  logic [OFF_W-1:0]  hdr_offset,
  input  tag_mode_e         hdr_mode,
  input  logic [MASK_W-1:0] hdr_mask,
  output logic              busy,
  output logic [OFF_W-1:0]  tag,
  output logic              last
);
  logic [CNT_W-1:0]  rem_q;
  logic [OFF_W-1:0]  base_q;
  logic [MASK_W-1:0] mask_q;
  tag_mode_e         mode_q;

  assign busy = (rem_q != '0);
  assign last = (rem_q == CNT_W'(1));

  always_comb begin
    case (mode_q)
      TAG_MASK: tag = base_q + OFF_W'(lowest_set(mask_q));
      default:  tag = base_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
      mode_q <= TAG_FIXED;
    end else if (accept) begin
      if (!busy) begin
        rem_q  <= hdr_count;
        base_q <= hdr_offset;
        mask_q <= hdr_mask;
        mode_q <= hdr_mode;
      end else begin
        rem_q <= rem_q - CNT_W'(1);
        if (mode_q == TAG_STEP) base_q <= base_q + OFF_W'(1);
        if (mode_q == TAG_MASK) mask_q <= mask_q & (mask_q - MASK_W'(1));
      end
    end
  end
endmodule

// File: rtl/cwp_out_slice.sv
module cwp_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/cmd_word_parser.sv
module cmd_word_parser
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_payload,
  output logic              out_last,
  output logic [WORD_W-1:0] out_data,
  output logic [OP_W-1:0]   out_opcode,
  output logic [CLS_W-1:0]  out_class,
  output logic [OFF_W-1:0]  out_offset,
  output logic [MASK_W-1:0] out_mask,
  output logic [CNT_W-1:0]  out_count,
  output logic [15:0]       out_imm,
  output logic [GCNT_W-1:0] out_gcount,
  output logic              out_insert,
  output logic              out_gtype,
  output logic              out_lock_acq,
  output logic              out_lock_rel,
  output logic              out_unknown,
  output logic [IDX_W-1:0]  out_index,
  output logic [WORD_W-1:0] out_restart_addr
);
  localparam int BEAT_W = $bits(beat_t);

  beat_t             hdr, beat, held;
  tag_mode_e         hdr_mode;
  logic [MASK_W-1:0] hdr_walk;
  logic              busy, seq_last, accept;
  logic [OFF_W-1:0]  tag;
  logic [BEAT_W-1:0] held_bits;

  assign accept = in_valid && in_ready;

  cwp_hdr_decode u_dec (
    .word(in_word), .hdr(hdr), .mode(hdr_mode), .walk_mask(hdr_walk)
  );

  cwp_payload_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .hdr_count(hdr.count), .hdr_offset(hdr.offset), .hdr_mode(hdr_mode),
    .hdr_mask(hdr_walk), .busy(busy), .tag(tag), .last(seq_last)
  );

  always_comb begin
    if (busy) begin
      beat            = '0;
      beat.is_payload = 1'b1;
      beat.last       = seq_last;
      beat.offset     = tag;
      beat.data       = in_word;
    end else begin
      beat = hdr;
    end
  end

  cwp_out_slice #(.W(BEAT_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(beat),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(held_bits)
  );

  assign held             = beat_t'(held_bits);
  assign out_payload      = held.is_payload;
  assign out_last         = held.last;
  assign out_data         = held.data;
  assign out_opcode       = held.opcode;
  assign out_class        = held.cls;
  assign out_offset       = held.offset;
  assign out_mask         = held.mask;
  assign out_count        = held.count;
  assign out_imm          = held.imm;
  assign out_gcount       = held.gcount;
  assign out_insert       = held.insert;
  assign out_gtype        = held.gtype;
  assign out_lock_acq     = held.acq;
  assign out_lock_rel     = held.rel;
  assign out_unknown      = held.unknown;
  assign out_index        = held.index;
  assign out_restart_addr = held.raddr;
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_payload,
  input logic        out_last,
  input logic [31:0] out_data,
  input logic [3:0]  out_opcode,
  input logic [11:0] out_offset,
  input logic [15:0] out_mask,
  input logic [15:0] out_count,
  input logic        out_lock_acq,
  input logic        out_lock_rel,
  input logic        out_unknown
);
  // R1
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R1
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_offset)
                                 && $stable(out_payload) && $stable(out_last));
  // R3
  setcl_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_payload && out_opcode == 4'h0 |-> out_count == 16'($countones(out_mask[5:0])));
  // R5
  masked_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_payload && out_opcode == 4'h3 |-> out_count == 16'($countones(out_mask)));
  // R6
  imm_no_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_payload && out_opcode == 4'h4 |-> out_count == 16'd0);
  // R9
  ext_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_lock_acq, out_lock_rel, out_unknown}));
  // R11
  last_on_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_payload);
endmodule

bind cmd_word_parser cwp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_payload(out_payload), .out_last(out_last),
  .out_data(out_data), .out_opcode(out_opcode), .out_offset(out_offset),
  .out_mask(out_mask), .out_count(out_count), .out_lock_acq(out_lock_acq),
  .out_lock_rel(out_lock_rel), .out_unknown(out_unknown)
);

// File: tb/tb_cmd_word_parser.sv
module tb_cmd_word_parser;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [31:0] in_word = '0;
  logic out_payload, out_last, out_insert, out_gtype, out_lock_acq, out_lock_rel, out_unknown;
  logic [31:0] out_data, out_restart_addr;
  logic [3:0]  out_opcode;
  logic [9:0]  out_class;
  logic [11:0] out_offset;
  logic [15:0] out_mask, out_count, out_imm;
  logic [13:0] out_gcount;
  logic [7:0]  out_index;

  always #2 clk = ~clk;

  cmd_word_parser dut (.*);

  typedef struct {
    logic pay, last; logic [31:0] data, raddr; logic [3:0] op; logic [9:0] cls;
    logic [11:0] off; logic [15:0] mask, cnt, imm; logic [13:0] gcnt;
    logic ins, gt, acq, rel, unk; logic [7:0] idx; string req;
  } exp_t;

  int tests = 0, fails = 0;
  exp_t exp_q[$];
  logic [31:0] stim[$];
  int m_rem = 0; int m_mode = 0; logic [11:0] m_off = '0; logic [15:0] m_mask = '0;

  function automatic int pc(input logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) n += m[i];
    return n;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Model of the requirements: mode 0 step, 1 fixed, 2 mask walk
  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    e = '{pay:0, last:0, data:w, raddr:0, op:0, cls:0, off:0, mask:0, cnt:0, imm:0,
          gcnt:0, ins:0, gt:0, acq:0, rel:0, unk:0, idx:0, req:"R2"};
    if (m_rem == 0) begin
      e.op = w[31:28]; m_mode = 1;
      case (w[31:28])
        4'h0: begin e.cls = w[15:6]; e.off = w[27:16]; e.mask = {10'b0, w[5:0]};
                    e.cnt = 16'(pc(e.mask)); m_mode = 2; e.req = "R3"; end
        4'h1, 4'h2: begin e.off = w[27:16]; e.cnt = w[15:0]; m_mode = (w[28]) ? 0 : 1; e.req = "R4"; end
        4'h3: begin e.off = w[27:16]; e.mask = w[15:0]; e.cnt = 16'(pc(e.mask)); m_mode = 2; e.req = "R5"; end
        4'h4: begin e.off = w[27:16]; e.imm = w[15:0]; e.req = "R6"; end
        4'h5: begin e.raddr = w << 4; e.req = "R7"; end
        4'h6: begin e.off = w[27:16]; e.ins = w[15]; e.gt = w[14]; e.gcnt = w[13:0];
                    e.cnt = 16'd1; e.req = "R8"; end
        4'hE: begin e.idx = w[7:0]; e.acq = (w[27:24] == 0); e.rel = (w[27:24] == 1);
                    e.unk = (w[27:24] > 1); e.req = "R9"; end
        default: ;
      endcase
      m_rem = int'(e.cnt); m_off = e.off; m_mask = e.mask;
    end else begin
      e.pay = 1; e.last = (m_rem == 1); m_rem--;
      if (m_mode == 2) begin
        int p = 0;
        for (int i = 15; i >= 0; i--) if (m_mask[i]) p = i;
        e.off = m_off + 12'(p); m_mask[p] = 1'b0; e.req = "R5";
      end else begin
        e.off = m_off; e.req = "R4";
        if (m_mode == 0) m_off = m_off + 12'd1;
      end
    end
    return e;
  endfunction

  task automatic compare(input exp_t e);
    chk(e.pay ? "R10" : "R2", "payload flag", 32'(out_payload), 32'(e.pay));
    chk("R11", "last", 32'(out_last), 32'(e.last));
    chk(e.req, "data", out_data, e.data);
    chk(e.req, "offset/tag", 32'(out_offset), 32'(e.off));
    if (!e.pay) begin
      chk("R2", "opcode", 32'(out_opcode), 32'(e.op));
      chk(e.req, "count", 32'(out_count), 32'(e.cnt));
      chk(e.req, "class", 32'(out_class), 32'(e.cls));
      chk(e.req, "mask", 32'(out_mask), 32'(e.mask));
      chk(e.req, "imm", 32'(out_imm), 32'(e.imm));
      chk(e.req, "restart addr", out_restart_addr, e.raddr);
      chk(e.req, "gather", {out_insert, out_gtype, out_gcount}, {e.ins, e.gt, e.gcnt});
      chk(e.req, "extend", {out_lock_acq, out_lock_rel, out_unknown, out_index},
          {e.acq, e.rel, e.unk, e.idx});
    end
  endtask

  initial begin
    logic stalled = 1'b0; logic [31:0] s_data = '0; logic [11:0] s_off = '0;
    int idx = 0, cyc = 0;
    void'($urandom(32'h5EED_0042));
    // directed corner cases
    stim = '{32'h0123_4AC0,                                    // set class, zero mask (R3, R11)
             32'h0ABC_0029, 32'hF000_0001, 32'h1000_0002, 32'h5000_0003, // mask 101001 -> tags +0,+3,+5
             32'h1FFE_0003, 32'h3000_0001, 32'h3000_0002, 32'h3000_0003, // step wraps at 4095 (R4)
             32'h2040_0002, 32'hAAAA_AAAA, 32'h5555_5555,     // fixed (R4)
             32'h3100_8005, 32'h0, 32'h1, 32'h2,               // mask bits 0,2,15 (R5)
             32'h3200_0000,                                    // empty mask
             32'h4055_BEEF, 32'h5123_4567,                     // R6, R7
             32'h6077_C005, 32'hE000_0000,                     // gather, payload looks like extend (R8, R10)
             32'hE000_0011, 32'hE100_0022, 32'hE700_0033,      // R9
             32'h9FFF_FFFF,                                    // R2 unused opcode
             32'h1010_0000, 32'h4001_0001};                    // zero count then header (R11)
    for (int k = 0; k < 500; k++) begin
      logic [31:0] r = $urandom;
      if (r[31:28] == 4'h1 || r[31:28] == 4'h2) r[15:3] = '0;
      stim.push_back(r);
    end

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "in_ready after reset", 32'(in_ready), 1);
    chk("R12", "out_valid after reset", 32'(out_valid), 0);

    while (idx < stim.size() || exp_q.size() != 0 || out_valid) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        tests++; fails++;
        $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 20000);
        break;
      end
      if (stalled) begin
        chk("R1", "held valid", 32'(out_valid), 1);
        chk("R1", "held data", out_data, s_data);
        chk("R1", "held offset", 32'(out_offset), 32'(s_off));
      end
      out_ready = ($urandom % 4) != 0;
      in_valid  = (idx < stim.size()) && (($urandom % 4) != 0);
      in_word   = (idx < stim.size()) ? stim[idx] : $urandom;
      #1;
      chk("R1", "in_ready rule", 32'(in_ready), 32'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R1 unexpected beat actual=1 expected=0");
        end else compare(exp_q.pop_front());
      end else if (!out_valid && exp_q.size() != 0) begin
        tests++; fails++;
        $display("FAIL R1 beat missing actual=0 expected=1");
      end
      stalled = out_valid && !out_ready;
      s_data = out_data; s_off = out_offset;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_word));
        idx++;
      end
    end
    in_valid = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule